// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits between five interrupt sources and a processor core. The sources are two external pins, two timer overflow flags, and one serial source that is active while either its receive flag or its transmit flag is set. Software sets three small configuration registers through a simple register port: an enable register with a master gate, a priority register, and a per-pin trigger-mode register. The enable and priority registers can be written a whole byte at a time or one bit at a time.

Every cycle the controller masks the pending sources with the enables and picks one. It offers that source to the core as a request with a fixed 16-bit vector. The core answers with an acknowledge pulse when it takes the vector and a return pulse when its handler ends. From these two pulses the controller tracks which priority levels are in service. A high-level request may interrupt a low-level handler. No other nesting is allowed.

Each external pin passes through a two-flop synchronizer. It is then used either as a level or as a rising-edge event that stays latched until it is acknowledged. The timer and serial flags are used as they arrive, so software that drives a timer flag high raises the same interrupt that a real overflow would.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the enable register, the priority register and the mode register all read 0, and no request is raised.
- R2: The request vector is 0x0003 for external pin 0, 0x000B for timer 0, 0x0013 for external pin 1, 0x001B for timer 1 and 0x0023 for serial. It is 0x0000 while no request is raised.
- R3: While enable bit 7 (master gate) is 0, no request is raised, whatever the other enable bits hold.
- R4: With the master gate at 1, a source can be requested only if its own enable bit is 1. The enable bits are: bit 0 external pin 0, bit 1 timer 0, bit 2 external pin 1, bit 3 timer 1, bit 4 serial.
- R5: When several requests of the same priority level are pending together, the winner is the first one in the order external 0, timer 0, external 1, timer 1, serial.
- R6: A high-level request preempts a low-level handler. A low-level request never preempts a low-level handler, and nothing preempts a high-level handler. A source is high level when its priority bit is 1: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1.
- R7: An acknowledge while a request is raised puts that request's level in service. A return pulse ends the high level if it is in service, otherwise the low level. A return pulse takes precedence over an acknowledge in the same cycle. A level-mode source that is still asserted is requested again after the return.
- R8: With a pin's mode bit at 1 (mode register bit 0 for pin 0, bit 1 for pin 1), the pin triggers on a rising edge. The event stays latched, even after the pin falls, until that source is acknowledged. A pin held high does not trigger again. With the mode bit at 0, the request follows the synchronized pin level.
- R9: The serial source is active while the receive flag or the transmit flag is set. It has one vector and has no priority bit, so it is always low level.
- R10: Register addresses are 0 for enable, 1 for priority and 2 for mode. A byte write loads the register. A bit write changes only the selected bit. Enable bit 6, priority bits 7 to 4 and mode bits 7 to 2 always read 0.
- R11: A timer flag input that is set while its source is enabled raises the request for as long as the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin_i | input | 2 | External interrupt pins, active high, asynchronous |
| tmr_flag_i | input | 2 | Timer overflow flags, index 0 for timer 0 |
| ser_rx_flag_i | input | 1 | Serial receive flag |
| ser_tx_flag_i | input | 1 | Serial transmit flag |
| cfg_wr_i | input | 1 | Byte write strobe |
| cfg_bit_wr_i | input | 1 | Single-bit write strobe, wins over a byte write |
| cfg_addr_i | input | 2 | Register address for writes |
| cfg_wdata_i | input | 8 | Byte write data |
| cfg_bit_idx_i | input | 3 | Bit position for a bit write |
| cfg_bit_val_i | input | 1 | Value for a bit write |
| cfg_rd_addr_i | input | 2 | Register address for reads |
| cfg_rdata_o | output | 8 | Read data, combinational |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vector_o | output | 16 | Vector address of the offered request |
| irq_ack_i | input | 1 | Core takes the offered vector |
| irq_reti_i | input | 1 | Core returns from a handler |

## Verification
Wrong nesting state shows up at the request port as a missing preemption or an illegal preemption. This appears in the first cycle after the acknowledge or return that corrupted the state. Wrong enable or priority decoding shows up as a wrong vector on the same cycle the inputs settle. A faulty edge latch either keeps offering a pin after it is acknowledged or loses a short pulse. Both are visible within a few cycles of the pin change, once the synchronizer delay has passed. Random mixes of enables, priorities and sources are compared against a bench model. Directed sequences walk through the nesting and edge cases.

// File: rtl/irqc_pkg.sv
// Package: shared constants and helpers for the two-level interrupt controller.
// Assumes source index order ext0, tmr0, ext1, tmr1, serial; this order is
// also the tie-break order and the enable/priority bit order.
package irqc_pkg;
    localparam int NEXT       = 2;             // external pins
    localparam int NSRC       = 2 * NEXT + 1;  // pins, timers, serial
    localparam int SER_IDX    = NSRC - 1;
    localparam int REG_W      = 8;
    localparam int VEC_W      = 16;
    localparam int VEC_BASE   = 3;
    localparam int VEC_STRIDE = 8;
    localparam int MASTER_BIT = 7;
    localparam int EN_RSVD    = 6;

    localparam logic [1:0] A_ENABLE = 2'd0;
    localparam logic [1:0] A_PRIO   = 2'd1;
    localparam logic [1:0] A_MODE   = 2'd2;

    // Fixed vector for a source index.
    function automatic logic [VEC_W-1:0] vec_of(input int unsigned idx);
        return VEC_W'(VEC_BASE + VEC_STRIDE * idx);
    endfunction
endpackage

// File: rtl/irqc_ext_detect.sv
// Module: one external pin front end. Synchronizes the pin with two flops,
// then presents either the level or a rising-edge event latched until the
// controller clears it on acknowledge. Assumes clr_i is a one-cycle pulse.
module irqc_ext_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic edge_mode_i,
    input  logic clr_i,
    output logic pend_o
);
    logic sync1_q, sync2_q, prev_q, evt_q;
    logic rise;

    assign rise = sync2_q & ~prev_q;

    // Two-flop synchronizer and previous-sample register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= pin_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    // Latched edge event: a new rise wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            evt_q <= 1'b0;
        else if (!edge_mode_i)
            evt_q <= 1'b0;
        else
            evt_q <= (evt_q & ~clr_i) | rise;
    end

    assign pend_o = edge_mode_i ? evt_q : sync2_q;

    AST_EDGE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i && clr_i && !rise) |=> !evt_q);                      // R8
    AST_EDGE_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_q) |-> $past(rise));                                    // R8
endmodule

// File: rtl/irqc_regs.sv
// Module: configuration registers (enable, priority, trigger mode) with byte
// and single-bit writes and a combinational read port. Unimplemented bits
// are masked at write time so they always read 0.
module irqc_regs
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             bit_wr_i,
    input  logic [1:0]       addr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic [2:0]       bit_idx_i,
    input  logic             bit_val_i,
    input  logic [1:0]       rd_addr_i,
    output logic [REG_W-1:0] rdata_o,
    output logic [REG_W-1:0] en_o,
    output logic [REG_W-1:0] prio_o,
    output logic [REG_W-1:0] mode_o
);
    localparam logic [REG_W-1:0] EN_MASK   = ~(REG_W'(1) << EN_RSVD);
    localparam logic [REG_W-1:0] PRIO_MASK = (REG_W'(1) << (NSRC - 1)) - 1'b1;
    localparam logic [REG_W-1:0] MODE_MASK = (REG_W'(1) << NEXT) - 1'b1;

    // Next value of one register for the current write.
    function automatic logic [REG_W-1:0] upd(input logic [REG_W-1:0] old,
                                            input logic [REG_W-1:0] mask,
                                            input logic bw,
                                            input logic [2:0] idx,
                                            input logic bv,
                                            input logic [REG_W-1:0] wd);
        logic [REG_W-1:0] r;
        r = old;
        if (bw) r[idx] = bv;
        else    r = wd;
        return r & mask;
    endfunction

    // Register update on byte or bit write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o   <= '0;
            prio_o <= '0;
            mode_o <= '0;
        end else if (wr_i || bit_wr_i) begin
            case (addr_i)
                A_ENABLE: en_o   <= upd(en_o,   EN_MASK,   bit_wr_i, bit_idx_i, bit_val_i, wdata_i);
                A_PRIO:   prio_o <= upd(prio_o, PRIO_MASK, bit_wr_i, bit_idx_i, bit_val_i, wdata_i);
                A_MODE:   mode_o <= upd(mode_o, MODE_MASK, bit_wr_i, bit_idx_i, bit_val_i, wdata_i);
                default:  ;
            endcase
        end
    end

    // Read multiplexer.
    always_comb begin
        case (rd_addr_i)
            A_ENABLE: rdata_o = en_o;
            A_PRIO:   rdata_o = prio_o;
            A_MODE:   rdata_o = mode_o;
            default:  rdata_o = '0;
        endcase
    end

    AST_BYTE_WRITE_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !bit_wr_i && addr_i == A_ENABLE) |=> en_o == ($past(wdata_i) & EN_MASK)); // R10
    AST_BIT_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_wr_i && addr_i == A_PRIO && bit_idx_i != 3'd0) |=> prio_o[0] == $past(prio_o[0])); // R10
endmodule

// File: rtl/irqc_arbiter.sv
// Module: two-level selection. Splits eligible sources into high and low
// candidates, applies the in-service nesting rule and picks the lowest
// index. Purely combinational; assumes eligibility already includes gating.
module irqc_arbiter
    import irqc_pkg::*;
(
    input  logic [NSRC-1:0]  elig_i,
    input  logic [NSRC-1:0]  prio_hi_i,
    input  logic             svc_hi_i,
    input  logic             svc_lo_i,
    output logic             req_o,
    output logic [NSRC-1:0]  grant_o,
    output logic             grant_hi_o,
    output logic [VEC_W-1:0] vector_o
);
    logic [NSRC-1:0] hi_c, lo_c, cand;
    logic            use_hi, use_lo;

    // Candidate level choice under the nesting rule.
    always_comb begin
        hi_c   = elig_i & prio_hi_i;
        lo_c   = elig_i & ~prio_hi_i;
        use_hi = !svc_hi_i && (|hi_c);
        use_lo = !svc_hi_i && !svc_lo_i && !(|hi_c) && (|lo_c);
        cand   = use_hi ? hi_c : (use_lo ? lo_c : '0);
    end

    // Lowest-index winner and its vector.
    always_comb begin
        grant_o  = cand & (~cand + 1'b1);
        req_o    = |grant_o;
        vector_o = '0;
        for (int i = 0; i < NSRC; i++)
            if (grant_o[i]) vector_o = vec_of(i);
        grant_hi_o = use_hi;
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
// Module: top of the two-level vectored interrupt controller. Builds the
// pending vector from pins, timer flags and serial flags, gates it with the
// enable register, arbitrates, and tracks in-service levels from the core's
// acknowledge and return pulses. Assumes ack and return are one-cycle pulses.
module irq_prio_ctrl
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NEXT-1:0]  ext_pin_i,
    input  logic [NEXT-1:0]  tmr_flag_i,
    input  logic             ser_rx_flag_i,
    input  logic             ser_tx_flag_i,
    input  logic             cfg_wr_i,
    input  logic             cfg_bit_wr_i,
    input  logic [1:0]       cfg_addr_i,
    input  logic [REG_W-1:0] cfg_wdata_i,
    input  logic [2:0]       cfg_bit_idx_i,
    input  logic             cfg_bit_val_i,
    input  logic [1:0]       cfg_rd_addr_i,
    output logic [REG_W-1:0] cfg_rdata_o,
    output logic             irq_req_o,
    output logic [VEC_W-1:0] irq_vector_o,
    input  logic             irq_ack_i,
    input  logic             irq_reti_i
);
    logic [REG_W-1:0] en_q, prio_q, mode_q;
    logic [NSRC-1:0]  pend, elig, prio_hi, grant;
    logic             grant_hi, take, svc_hi_q, svc_lo_q;

    irqc_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_i(cfg_wr_i), .bit_wr_i(cfg_bit_wr_i), .addr_i(cfg_addr_i),
        .wdata_i(cfg_wdata_i), .bit_idx_i(cfg_bit_idx_i), .bit_val_i(cfg_bit_val_i),
        .rd_addr_i(cfg_rd_addr_i), .rdata_o(cfg_rdata_o),
        .en_o(en_q), .prio_o(prio_q), .mode_o(mode_q)
    );

    assign take = irq_ack_i && irq_req_o && !irq_reti_i;

    // Per pin pair: external detector at even index, timer flag at odd index.
    for (genvar k = 0; k < NEXT; k++) begin : g_src
        irqc_ext_detect u_ext (
            .clk(clk), .rst_n(rst_n), .pin_i(ext_pin_i[k]),
            .edge_mode_i(mode_q[k]), .clr_i(take && grant[2*k]),
            .pend_o(pend[2*k])
        );
        assign pend[2*k+1] = tmr_flag_i[k];
    end
    assign pend[SER_IDX] = ser_rx_flag_i | ser_tx_flag_i;

    assign elig    = pend & en_q[NSRC-1:0] & {NSRC{en_q[MASTER_BIT]}};
    assign prio_hi = {1'b0, prio_q[NSRC-2:0]};

    irqc_arbiter u_arb (
        .elig_i(elig), .prio_hi_i(prio_hi),
        .svc_hi_i(svc_hi_q), .svc_lo_i(svc_lo_q),
        .req_o(irq_req_o), .grant_o(grant), .grant_hi_o(grant_hi),
        .vector_o(irq_vector_o)
    );

    // In-service tracking: return ends the newest level, ack opens one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_hi_q <= 1'b0;
            svc_lo_q <= 1'b0;
        end else if (irq_reti_i) begin
            if (svc_hi_q) svc_hi_q <= 1'b0;
            else          svc_lo_q <= 1'b0;
        end else if (take) begin
            if (grant_hi) svc_hi_q <= 1'b1;
            else          svc_lo_q <= 1'b1;
        end
    end

    AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[MASTER_BIT] |-> !irq_req_o);                                // R3
    AST_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> ((grant & ~en_q[NSRC-1:0]) == '0));                 // R4
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));                                                 // R5
    AST_HI_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        svc_hi_q |-> !irq_req_o);                                         // R6
    AST_LO_NEEDS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_lo_q && irq_req_o) |-> grant_hi);                            // R6
    AST_RETI_HI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_reti_i && svc_hi_q) |=> (!svc_hi_q && svc_lo_q == $past(svc_lo_q))); // R7
    AST_ACK_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (svc_hi_q || svc_lo_q));                                 // R7
    AST_SERIAL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        grant[SER_IDX] |-> !grant_hi);                                    // R9
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_pin = '0, tmr_flag = '0;
    logic        rx = 1'b0, tx = 1'b0;
    logic        wr = 1'b0, bwr = 1'b0, bval = 1'b0;
    logic [1:0]  addr = '0, raddr = '0;
    logic [7:0]  wdata = '0, rdata;
    logic [2:0]  bidx = '0;
    logic        req, ack = 1'b0, reti = 1'b0;
    logic [15:0] vec;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .tmr_flag_i(tmr_flag),
        .ser_rx_flag_i(rx), .ser_tx_flag_i(tx),
        .cfg_wr_i(wr), .cfg_bit_wr_i(bwr), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
        .cfg_bit_idx_i(bidx), .cfg_bit_val_i(bval), .cfg_rd_addr_i(raddr),
        .cfg_rdata_o(rdata), .irq_req_o(req), .irq_vector_o(vec),
        .irq_ack_i(ack), .irq_reti_i(reti)
    );

    // Model: expected {req, vector} from requirements.
    function automatic logic [16:0] model(input logic [7:0] en, input logic [7:0] pr,
                                          input logic [5:0] s, input logic sh, input logic sl);
        logic [4:0] pend, el, hi, lo, c;
        pend = {s[4] | s[5], s[3:0]};
        el   = en[7] ? (pend & en[4:0]) : 5'b0;
        hi   = el & {1'b0, pr[3:0]};
        lo   = el & ~hi;
        c    = sh ? 5'b0 : ((hi != 0) ? hi : (sl ? 5'b0 : lo));
        for (int i = 0; i < 5; i++)
            if (c[i]) return {1'b1, 16'(3 + 8 * i)};
        return 17'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_irq(input string tag, input logic er, input logic [15:0] ev);
        check(tag, {15'd0, req, vec}, {15'd0, er, ev});
    endtask

    task automatic settle(); repeat (4) @(negedge clk); endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ext_pin = '0; tmr_flag = '0; rx = 0; tx = 0; ack = 0; reti = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_byte(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic wr_bit(input logic [1:0] a, input logic [2:0] i, input logic v);
        @(negedge clk); bwr = 1'b1; addr = a; bidx = i; bval = v;
        @(negedge clk); bwr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); raddr = a; #1 d = rdata;
    endtask

    task automatic pulse_ack();  @(negedge clk); ack = 1;  @(negedge clk); ack = 0;  endtask
    task automatic pulse_reti(); @(negedge clk); reti = 1; @(negedge clk); reti = 0; endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd2024));
        do_reset();

        // R1 reset state
        rd(0, d); check("R1 enable", d, 0);
        rd(1, d); check("R1 prio", d, 0);
        rd(2, d); check("R1 mode", d, 0);
        chk_irq("R1 no request", 0, 16'h0);

        // R10 register access
        wr_byte(0, 8'hFF); rd(0, d); check("R10 enable bit6 zero", d, 8'hBF);
        wr_byte(1, 8'hFF); rd(1, d); check("R10 prio upper zero", d, 8'h0F);
        wr_byte(2, 8'hFF); rd(2, d); check("R10 mode upper zero", d, 8'h03);
        wr_bit(0, 3'd7, 1'b0); rd(0, d); check("R10 bit write enable", d, 8'h3F);
        wr_bit(1, 3'd5, 1'b1); rd(1, d); check("R10 bit write unimpl", d, 8'h0F);
        wr_bit(1, 3'd2, 1'b0); rd(1, d); check("R10 bit clear prio", d, 8'h0B);

        // R2 each vector alone
        do_reset();
        wr_byte(0, 8'h9F);
        for (int i = 0; i < 5; i++) begin
            ext_pin = '0; tmr_flag = '0; rx = 0;
            case (i)
                0: ext_pin[0] = 1; 1: tmr_flag[0] = 1;
                2: ext_pin[1] = 1; 3: tmr_flag[1] = 1;
                default: rx = 1;
            endcase
            settle();
            chk_irq("R2 vector", 1, 16'(3 + 8 * i));
        end
        ext_pin = '0; tmr_flag = '0; rx = 0;

        // R3 master gate, R4 own enable
        do_reset();
        wr_byte(0, 8'h1F); tmr_flag[0] = 1; settle();
        chk_irq("R3 master off", 0, 16'h0);
        wr_bit(0, 3'd7, 1'b1); settle();
        chk_irq("R3 master on", 1, 16'h000B);
        wr_byte(0, 8'h81); settle();
        chk_irq("R4 source disabled", 0, 16'h0);

        // R5 same-level order
        do_reset();
        wr_byte(0, 8'h9F); ext_pin = 2'b11; tmr_flag = 2'b11; tx = 1; settle();
        chk_irq("R5 ext0 first", 1, 16'h0003);
        ext_pin[0] = 0; settle(); chk_irq("R5 tmr0 next", 1, 16'h000B);
        tmr_flag[0] = 0; settle(); chk_irq("R5 ext1 next", 1, 16'h0013);

        // R6/R7 nesting
        do_reset();
        wr_byte(0, 8'h9F); wr_byte(1, 8'h08);
        ext_pin[0] = 1; settle(); chk_irq("R6 low offered", 1, 16'h0003);
        pulse_ack(); settle();
        chk_irq("R6 low blocks same source", 0, 16'h0);
        tmr_flag[0] = 1; settle(); chk_irq("R6 low no preempt low", 0, 16'h0);
        tmr_flag[1] = 1; settle(); chk_irq("R6 high preempts low", 1, 16'h001B);
        pulse_ack(); wr_byte(1, 8'h0C); ext_pin[1] = 1; settle();
        chk_irq("R6 nothing preempts high", 0, 16'h0);
        pulse_reti(); settle(); chk_irq("R7 high ended first", 1, 16'h0013);
        ext_pin[1] = 0; tmr_flag = '0; settle();
        chk_irq("R7 low still in service", 0, 16'h0);
        pulse_reti(); settle(); chk_irq("R7 level refires", 1, 16'h0003);

        // R8 edge mode
        do_reset();
        wr_byte(0, 8'h81); wr_byte(2, 8'h01);
        ext_pin[0] = 1; settle(); chk_irq("R8 edge latched", 1, 16'h0003);
        pulse_ack(); pulse_reti(); settle();
        chk_irq("R8 held pin no retrigger", 0, 16'h0);
        ext_pin[0] = 0; settle(); ext_pin[0] = 1;
        repeat (2) @(negedge clk); ext_pin[0] = 0; settle();
        chk_irq("R8 short pulse kept", 1, 16'h0003);
        wr_byte(2, 8'h00); settle(); ext_pin[0] = 1;
        repeat (2) @(negedge clk); ext_pin[0] = 0; settle();
        chk_irq("R8 level pulse gone", 0, 16'h0);

        // R9 serial
        do_reset();
        wr_byte(0, 8'h90); wr_byte(1, 8'h0F);
        rx = 1; settle(); chk_irq("R9 rx", 1, 16'h0023);
        rx = 0; tx = 1; settle(); chk_irq("R9 tx", 1, 16'h0023);
        pulse_ack(); wr_byte(0, 8'h98); tmr_flag[1] = 1; settle();
        chk_irq("R9 serial is low level", 1, 16'h001B);

        // R11 software timer flag
        do_reset();
        wr_byte(0, 8'h88); tmr_flag[1] = 1; settle();
        chk_irq("R11 sw flag set", 1, 16'h001B);
        tmr_flag[1] = 0; settle(); chk_irq("R11 sw flag cleared", 0, 16'h0);

        // R5 / R2 random mixes, nothing in service
        do_reset();
        for (int it = 0; it < 200; it++) begin
            logic [7:0] en, pr;
            logic [5:0] s;
            logic [16:0] e;
            en = 8'($urandom) & 8'hBF;
            if (($urandom % 4) != 0) en[7] = 1;
            pr = 8'($urandom) & 8'h0F;
            s  = 6'($urandom);
            wr_byte(0, en); wr_byte(1, pr);
            ext_pin = {s[2], s[0]}; tmr_flag = {s[3], s[1]}; rx = s[4]; tx = s[5];
            settle();
            e = model(en, pr, s, 0, 0);
            chk_irq("R5 random", e[16], e[15:0]);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule